// File: doc/BRIEF.md
# Watchdog Timer Mode Controller

This block is a watchdog timer with a single 8-bit control and status register. A free-running counter counts watchdog clock cycles. When it reaches the selected period it produces a time-out. The register chooses how the block answers a time-out. In interrupt mode it sets a flag. In reset mode it requests a system reset. In combined mode the first time-out raises an interrupt, and a later one resets the system.

Software keeps the watchdog quiet by pulsing the kick input, which restarts the counter. The interrupt request is gated by a global interrupt enable supplied from outside. Two fields can weaken the watchdog: clearing the reset enable and changing the period. Both are protected by a timed unlock sequence. The reset value of the reset enable comes from an external pin, so a system can start with the watchdog already armed.

Top module: `wdt_mode_ctrl`

## Requirements
- R1: The register reads as {bit 7 time-out flag, bit 6 interrupt enable, bit 5 period code bit 3, bit 4 change-window open, bit 3 reset enable, bits 2..0 period code bits 2..0}. A write uses the same positions.
- R2: When a time-out occurs while the interrupt enable is 1, the time-out flag is set on the same clock edge.
- R3: The flag clears when irq_ack is pulsed, or when a register write has bit 7 at 1. A write with bit 7 at 0 leaves the flag unchanged. If a time-out sets the flag on the same edge as a clear, the set wins.
- R4: irq_req is 1 exactly when the flag, the interrupt enable and gie are all 1.
- R5: In interrupt mode (interrupt enable 1, reset enable 0), a time-out never asserts sys_rst_req, and an acknowledge leaves the interrupt enable at 1.
- R6: In reset mode (interrupt enable 0, reset enable 1), a time-out asserts sys_rst_req. It then stays asserted until rst_n is asserted.
- R7: In combined mode (interrupt enable 1, reset enable 1), a time-out with the flag clear only sets the flag. An acknowledge while the flag is set clears both the flag and the interrupt enable. A later time-out then resets the system, and so does a time-out that arrives while the flag is still set.
- R8: After reset the register reads 0, except bit 3, which equals wde_rst_val.
- R9: Period code n gives a time-out every 2^(BASE_EXP+n) cycles for n from 0 to 9. Codes 10 to 15 behave as code 9.
- R10: A write with bits 4 and 3 both at 1 opens a change window of WIN_CYCLES cycles, during which bit 4 reads 1. The first write inside the window may clear the reset enable and load the period code, and it closes the window. Outside the window, period code bits in a write are ignored and a 0 in bit 3 is ignored. Setting the reset enable is always allowed.
- R11: A kick, or a write accepted inside the change window, restarts the counter from zero. The next time-out then comes one full period after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wde_rst_val | input | 1 | Value loaded into the reset enable during reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| kick | input | 1 | Restart the time-out counter |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| gie | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Interrupt request |
| sys_rst_req | output | 1 | System reset request, held until reset |

## Verification
Combined mode is the hardest case to reach. The bench has to land a time-out, an acknowledge and a second time-out in a fixed order inside short periods. It also has to produce the variant where the acknowledge never comes. The bench reduces BASE_EXP so that periods are a few cycles long. It aligns the counter with a kick and places each acknowledge on a known edge between the two time-outs. The change window is probed on its last open cycle and on the first closed cycle by counting idle edges after the opening write.

// File: rtl/wdt_mode_pkg.sv
package wdt_mode_pkg;

  // Bit positions of the control/status register
  localparam int unsigned POS_FLAG = 7;
  localparam int unsigned POS_IE   = 6;
  localparam int unsigned POS_PS3  = 5;
  localparam int unsigned POS_CE   = 4;
  localparam int unsigned POS_WDE  = 3;

  // Largest period code that still lengthens the period
  localparam int unsigned MAX_CODE = 9;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic       wde;
    logic [3:0] ps;
  } ctrl_t;

  // Exponent of the period for a code, with the top codes saturated
  function automatic int unsigned period_exp(logic [3:0] code, int unsigned base);
    int unsigned n;
    n = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
    return base + n;
  endfunction

  function automatic logic [3:0] wdata_ps(logic [7:0] d);
    return {d[POS_PS3], d[2:0]};
  endfunction

  function automatic logic [7:0] pack_ctrl(ctrl_t c, logic ce);
    logic [7:0] r;
    r            = 8'h00;
    r[POS_FLAG]  = c.flag;
    r[POS_IE]    = c.ie;
    r[POS_PS3]   = c.ps[3];
    r[POS_CE]    = ce;
    r[POS_WDE]   = c.wde;
    r[2:0]       = c.ps[2:0];
    return r;
  endfunction

endpackage

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
  import wdt_mode_pkg::*;
#(
  parameter int unsigned BASE_EXP = 11,
  localparam int unsigned CNT_W   = BASE_EXP + MAX_CODE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [3:0]       ps_code,
  output logic             timeout_evt,
  output logic [CNT_W-1:0] cnt_q
);

  logic [CNT_W-1:0] last_val;

  assign last_val    = CNT_W'((64'd1 << period_exp(ps_code, BASE_EXP)) - 64'd1);
  assign timeout_evt = (cnt_q == last_val) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || (cnt_q == last_val)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_change_window.sv
module wdt_change_window #(
  parameter int unsigned WIN_CYCLES = 4,
  localparam int unsigned WIN_W     = $clog2(WIN_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic close_req,
  output logic win_open
);

  logic [WIN_W-1:0] left_q;

  assign win_open = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (open_req) begin
      left_q <= WIN_W'(WIN_CYCLES);
    end else if (close_req) begin
      left_q <= '0;
    end else if (win_open) begin
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wde_rst_val,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       win_open,
  input  logic       timeout_evt,
  input  logic       irq_ack,
  output ctrl_t      ctrl_q,
  output logic       prot_wr,
  output logic       open_req,
  output logic       flag_set_evt,
  output logic       ie_hw_clr,
  output logic       rst_evt
);

  logic wr_flag_clr;
  logic wr_wde_set;

  // Protected fields are only taken from a write inside the window
  assign prot_wr      = reg_wr && win_open;
  assign open_req     = reg_wr && !win_open && reg_wdata[POS_CE] && reg_wdata[POS_WDE];
  assign wr_flag_clr  = reg_wr && reg_wdata[POS_FLAG];
  assign wr_wde_set   = reg_wr && reg_wdata[POS_WDE];

  assign flag_set_evt = timeout_evt && ctrl_q.ie;
  assign ie_hw_clr    = irq_ack && ctrl_q.flag && ctrl_q.wde;
  assign rst_evt      = timeout_evt && ctrl_q.wde && (!ctrl_q.ie || ctrl_q.flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.flag <= 1'b0;
      ctrl_q.ie   <= 1'b0;
      ctrl_q.wde  <= wde_rst_val;
      ctrl_q.ps   <= 4'd0;
    end else begin
      if (flag_set_evt) begin
        ctrl_q.flag <= 1'b1;
      end else if (irq_ack || wr_flag_clr) begin
        ctrl_q.flag <= 1'b0;
      end

      if (ie_hw_clr) begin
        ctrl_q.ie <= 1'b0;
      end else if (reg_wr) begin
        ctrl_q.ie <= reg_wdata[POS_IE];
      end

      if (wr_wde_set) begin
        ctrl_q.wde <= 1'b1;
      end else if (prot_wr) begin
        ctrl_q.wde <= 1'b0;
      end

      if (prot_wr) begin
        ctrl_q.ps <= wdata_ps(reg_wdata);
      end
    end
  end

endmodule

// File: rtl/wdt_mode_ctrl.sv
module wdt_mode_ctrl
  import wdt_mode_pkg::*;
#(
  parameter int unsigned BASE_EXP   = 11,
  parameter int unsigned WIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wde_rst_val,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       kick,
  input  logic       irq_ack,
  input  logic       gie,
  output logic       irq_req,
  output logic       sys_rst_req
);

  localparam int unsigned CNT_W = BASE_EXP + MAX_CODE;

  ctrl_t            ctrl_q;
  logic             prot_wr;
  logic             open_req;
  logic             win_open;
  logic             restart;
  logic             timeout_evt;
  logic             flag_set_evt;
  logic             ie_hw_clr;
  logic             rst_evt;
  logic [CNT_W-1:0] cnt_q;

  assign restart = kick || prot_wr;

  wdt_tick_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .ps_code     (ctrl_q.ps),
    .timeout_evt (timeout_evt),
    .cnt_q       (cnt_q)
  );

  wdt_change_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_req  (open_req),
    .close_req (prot_wr),
    .win_open  (win_open)
  );

  wdt_ctrl_reg u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wde_rst_val  (wde_rst_val),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .win_open     (win_open),
    .timeout_evt  (timeout_evt),
    .irq_ack      (irq_ack),
    .ctrl_q       (ctrl_q),
    .prot_wr      (prot_wr),
    .open_req     (open_req),
    .flag_set_evt (flag_set_evt),
    .ie_hw_clr    (ie_hw_clr),
    .rst_evt      (rst_evt)
  );

  assign reg_rdata = pack_ctrl(ctrl_q, win_open);
  assign irq_req   = ctrl_q.flag && ctrl_q.ie && gie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_rst_req <= 1'b0;
    end else if (rst_evt) begin
      sys_rst_req <= 1'b1;
    end
  end

endmodule

// File: rtl/wdt_mode_ctrl_chk.sv
module wdt_mode_ctrl_chk #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic             irq_req,
  input logic             irq_ack,
  input logic             kick,
  input logic             timeout_evt,
  input logic             win_open,
  input logic             flag,
  input logic             ie,
  input logic             wde,
  input logic [3:0]       ps,
  input logic [CNT_W-1:0] cnt_q,
  input logic             sys_rst_req
);

  // R4
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_req);

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && ie) |=> flag);

  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !timeout_evt) |=> !flag);

  // R6
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);

  // R6
  rst_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && wde && !ie) |=> sys_rst_req);

  // R5
  int_mode_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_req && !wde) |=> !sys_rst_req);

  // R7
  combined_ie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && flag && wde) |=> !ie);

  // R10
  ps_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> (ps == $past(ps)));

  // R11
  kick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0));

endmodule

bind wdt_mode_ctrl wdt_mode_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gie         (gie),
  .irq_req     (irq_req),
  .irq_ack     (irq_ack),
  .kick        (kick),
  .timeout_evt (timeout_evt),
  .win_open    (win_open),
  .flag        (ctrl_q.flag),
  .ie          (ctrl_q.ie),
  .wde         (ctrl_q.wde),
  .ps          (ctrl_q.ps),
  .cnt_q       (cnt_q),
  .sys_rst_req (sys_rst_req)
);

// File: tb/wdt_mode_ctrl_test.sv
`timescale 1ns/1ps
module wdt_mode_ctrl_test;

  localparam int unsigned TB_BASE = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wde_rst_val = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       kick = 1'b0;
  logic       irq_ack = 1'b0;
  logic       gie = 1'b0;
  logic       irq_req;
  logic       sys_rst_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  wdt_mode_ctrl #(.BASE_EXP(TB_BASE), .WIN_CYCLES(4)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wde_rst_val (wde_rst_val),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .kick        (kick),
    .irq_ack     (irq_ack),
    .gie         (gie),
    .irq_req     (irq_req),
    .sys_rst_req (sys_rst_req)
  );

  typedef struct packed {
    logic [3:0]  code;
    logic [31:0] period;
  } vec_t;

  // period code -> expected period with BASE_EXP = 2
  localparam vec_t VEC [8] = '{
    '{4'd0,  32'd4},    '{4'd1,  32'd8},    '{4'd3,  32'd32},
    '{4'd5,  32'd128},  '{4'd9,  32'd2048}, '{4'd10, 32'd2048},
    '{4'd15, 32'd2048}, '{4'd2,  32'd16}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [7:0] v);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = 8'h00;
  endtask

  task automatic pulse_kick();
    kick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic do_reset(logic wv);
    rst_n = 1'b0;
    wde_rst_val = wv;
    gie = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  task automatic wait_flag(output int n, input int limit);
    n = 0;
    while (n < limit) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (reg_rdata[7]) break;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk);

    // R8: reset value with reset enable pin high, R6: reset-only from reset
    do_reset(1'b1);
    chk("R8 reset value pin=1", reg_rdata, 8'h08);
    n = 0;
    while (n < 20 && !sys_rst_req) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    chk("R6 reset-only period", n, 4);
    idle(10);
    chk("R6 reset request sticky", sys_rst_req, 1'b1);

    // R10: change window
    do_reset(1'b1);
    wr(8'h05);
    chk("R10 period code locked", reg_rdata, 8'h08);
    wr(8'h00);
    chk("R10 reset enable clear locked", reg_rdata, 8'h08);
    wr(8'h18);
    chk("R10 window open readback", reg_rdata, 8'h18);
    idle(3);
    wr(8'h03);
    chk("R10 write on last window cycle", reg_rdata, 8'h03);
    wr(8'h08);
    wr(8'h18);
    idle(4);
    chk("R10 window closed after expiry", reg_rdata, 8'h0B);
    wr(8'h00);
    chk("R10 write after expiry rejected", reg_rdata, 8'h0B);

    // R1, R9, R11: vector table in interrupt mode
    do_reset(1'b0);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'hC0 | {2'b00, VEC[i].code[3], 5'b0} | {5'b0, VEC[i].code[2:0]};
      wr(8'hD8);
      wr(v);
      chk("R1 readback of code", reg_rdata, v & 8'h7F);
      wait_flag(n, 5000);
      chk("R9 R11 period after code write", n, VEC[i].period);
    end
    chk("R5 no reset in interrupt mode", sys_rst_req, 1'b0);

    // R11: kicks hold off the time-out (period 4)
    do_reset(1'b0);
    wr(8'h40);
    pulse_kick();
    for (int k = 0; k < 10; k++) begin
      idle(2);
      pulse_kick();
    end
    chk("R11 kicks hold off flag", reg_rdata[7], 1'b0);
    wait_flag(n, 20);
    chk("R11 period after last kick", n, 4);

    // R2, R3, R4, R5: flag and interrupt gating
    do_reset(1'b0);
    wr(8'h40);
    pulse_kick();
    wait_flag(n, 20);
    chk("R2 flag set on time-out", n, 4);
    chk("R4 irq blocked by gie", irq_req, 1'b0);
    gie = 1'b1;
    #0.5;
    chk("R4 irq with gie", irq_req, 1'b1);
    pulse_ack();
    chk("R3 R5 ack clears flag keeps ie", reg_rdata, 8'h40);
    chk("R4 irq drops after ack", irq_req, 1'b0);
    wait_flag(n, 20);
    wr(8'h40);
    chk("R3 write zero keeps flag", reg_rdata[7], 1'b1);
    wr(8'hC0);
    chk("R3 write one clears flag", reg_rdata[7], 1'b0);
    chk("R5 interrupt mode never resets", sys_rst_req, 1'b0);

    // R7: combined mode, acknowledged first time-out
    do_reset(1'b0);
    wr(8'h48);
    pulse_kick();
    wait_flag(n, 20);
    chk("R7 first time-out flag only", n, 4);
    chk("R7 no reset on first time-out", sys_rst_req, 1'b0);
    pulse_ack();
    chk("R7 ack clears flag and ie", reg_rdata, 8'h08);
    idle(2);
    chk("R7 no reset before second time-out", sys_rst_req, 1'b0);
    idle(1);
    chk("R7 second time-out resets", sys_rst_req, 1'b1);

    // R7: combined mode, flag left pending
    do_reset(1'b0);
    wr(8'h48);
    pulse_kick();
    wait_flag(n, 20);
    idle(3);
    chk("R7 pending flag no reset yet", sys_rst_req, 1'b0);
    idle(1);
    chk("R7 pending flag escalates", sys_rst_req, 1'b1);

    // R8: reset value with pin low
    do_reset(1'b0);
    chk("R8 reset value pin=0", reg_rdata, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule